// File: doc/BRIEF.md
# E3 Transmit Payload Input Interface

This block sits between the terminal equipment and a transmit framer and collects the E3 payload. It times each bit period, tells the terminal equipment when to present data, captures that data and hands one bit per period to the framer. Each bit carries flags for frame overhead and for the end of the frame. The framer places its own overhead bits in the flagged positions.

Three configuration inputs give six operating modes. The data path is serial (one bit per period) or nibble (four bits every fourth period). Timing is loop-timed or local-timed. In loop timing, bit periods come from an enable qualified by the recovered receive line clock. In local timing, they come from an enable qualified by the local transmit clock. A local-timed port is either frame master, with a free-running frame count, or frame slave, where a frame-start strobe from the terminal equipment realigns the count. Both clocks are modelled as enables inside one clock domain. The mode is captured only while the synchronous reset is high.

Top module: `e3_payload_ingress`

## Requirements
- R1: The pins `cfg_nibble`, `cfg_local` and `cfg_master` select the six modes. `cfg_master` matters only when `cfg_local` is 1. The values are captured on every clock edge at which `srst` is high.
- R2: With `cfg_local`=0, a bit period is a cycle in which `rx_line_en` is high, and `tx_local_en` has no effect. With `cfg_local`=1, a bit period is a cycle in which `tx_local_en` is high, and `rx_line_en` has no effect.
- R3: In serial modes, `term_req_o` is high, combinationally, in every payload bit period. `ser_data_i` is sampled at the rising edge that closes that period and appears on `tx_bit_o` in the following cycle.
- R4: In nibble modes, `term_req_o` is high only in payload bit periods whose position modulo 4 is 0. `nib_data_i` is sampled in that period. Bits 3, 2, 1 and 0 appear on `tx_bit_o` for positions p, p+1, p+2 and p+3, so two requests never fall in consecutive cycles.
- R5: A frame has 1536 positions, numbered 0 to 1535, and the count wraps from 1535 to 0. `tx_eof_o` is high for exactly the one output cycle that carries position 1535.
- R6: Positions 0 to 11 are overhead. For these positions `tx_oh_o` is 1, `tx_bit_o` is 0 and no request is raised.
- R7: In loop-timed modes and in frame-master modes, the count runs freely and `frame_start_i` has no effect.
- R8: In frame-slave modes, `frame_start_i` sampled high in any cycle makes the next bit period position 0. A strobe that falls in a bit period applies to that period, and a strobe in the middle of a frame realigns the count.
- R9: A change of the configuration pins while `srst` is low has no effect until the next reset. `srst` clears the count, a pending frame start, the nibble register and all outputs.
- R10: The outputs to the framer are registered. `tx_vld_o` is high in exactly the cycles that follow a bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single synthesis clock |
| srst | input | 1 | Synchronous reset, active high; captures the mode |
| cfg_nibble | input | 1 | 1 = nibble data path, 0 = serial |
| cfg_local | input | 1 | 1 = local-timed, 0 = loop-timed |
| cfg_master | input | 1 | In local timing: 1 = frame master, 0 = frame slave |
| rx_line_en | input | 1 | Bit enable from the recovered receive clock |
| tx_local_en | input | 1 | Bit enable from the local transmit clock |
| frame_start_i | input | 1 | Frame-start strobe from the terminal equipment (slave modes) |
| ser_data_i | input | 1 | Serial payload bit |
| nib_data_i | input | 4 | Payload nibble, bit 3 sent first |
| term_req_o | output | 1 | Data request / payload clock toward the terminal equipment |
| tx_vld_o | output | 1 | A bit is present for the framer |
| tx_bit_o | output | 1 | Payload bit toward the framer (0 in overhead positions) |
| tx_oh_o | output | 1 | The bit position is overhead |
| tx_eof_o | output | 1 | The bit position is the last of the frame |

## Verification
Several properties are checked by the assertions on every cycle:
- the count returns to 0 after position 1535;
- the end-of-frame flag never lasts two cycles and never marks an overhead position;
- each bit period is followed by a valid output;
- nibble requests are never adjacent;
- the nibble register holds between loads;
- the captured mode stays put outside reset.

Other behaviour needs the bench's directed scenarios, which compare the outputs with a bench-side frame model. These cover the sampled data value and its order inside a nibble, the disregarded clock enable, a mid-frame resynchronisation in a slave mode, and a configuration change that waits for reset.

// File: rtl/e3pi_pkg.sv
package e3pi_pkg;

  typedef struct packed {
    logic nibble;
    logic local_t;
    logic master;
  } e3pi_mode_t;

  // Overhead occupies the first oh_len positions of a frame.
  function automatic logic pos_is_oh(input int unsigned pos, input int unsigned oh_len);
    return pos < oh_len;
  endfunction

  // Position following pos, wrapping after last.
  function automatic int unsigned next_pos(input int unsigned pos, input int unsigned last);
    return (pos == last) ? 0 : pos + 1;
  endfunction

  // Index of a position inside its nibble group.
  function automatic int unsigned lane_of(input int unsigned pos, input int unsigned width);
    return pos % width;
  endfunction

endpackage

// File: rtl/e3pi_bit_timer.sv
module e3pi_bit_timer
  import e3pi_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1536,
  localparam int unsigned CW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          srst,
  input  e3pi_mode_t    mode,
  input  logic          rx_line_en,
  input  logic          tx_local_en,
  input  logic          frame_start_i,
  output logic          bit_en_o,
  output logic [CW-1:0] pos_o
);

  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);

  logic [CW-1:0] cnt_q;
  logic          fs_pend_q;
  logic          slave;
  logic          take_start;

  assign slave      = mode.local_t & ~mode.master;
  assign bit_en_o   = ~srst & (mode.local_t ? tx_local_en : rx_line_en);
  assign take_start = slave & (fs_pend_q | frame_start_i);
  assign pos_o      = take_start ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt_q     <= '0;
      fs_pend_q <= 1'b0;
    end else begin
      if (bit_en_o) begin
        cnt_q <= CW'(next_pos(32'(pos_o), FRAME_BITS - 1));
      end
      if (bit_en_o) begin
        fs_pend_q <= 1'b0;
      end else if (slave && frame_start_i) begin
        fs_pend_q <= 1'b1;
      end
    end
  end

  // R5: the count returns to zero after the last position
  p_wrap_r5: assert property (@(posedge clk) disable iff (srst)
    (bit_en_o && pos_o == LAST_POS) |=> (cnt_q == '0));

  // R7: a pending start exists only in a slave mode
  p_pend_slave_only_r7: assert property (@(posedge clk) disable iff (srst)
    fs_pend_q |-> slave);

endmodule

// File: rtl/e3pi_nibble_unpack.sv
module e3pi_nibble_unpack
  import e3pi_pkg::*;
#(
  parameter int unsigned NW = 4,
  localparam int unsigned LW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          srst,
  input  logic          load,
  input  logic [LW-1:0] lane,
  input  logic [NW-1:0] nib_in,
  output logic          bit_o
);

  logic [NW-1:0] nib_q;

  // Lane 0 takes the top bit straight from the input; later lanes use the held copy.
  assign bit_o = (lane == '0) ? nib_in[NW-1] : nib_q[NW - 1 - int'(lane)];

  always_ff @(posedge clk) begin
    if (srst) begin
      nib_q <= '0;
    end else if (load) begin
      nib_q <= nib_in;
    end
  end

  // R4: the held nibble changes only on a load
  p_hold_r4: assert property (@(posedge clk) disable iff (srst)
    !load |=> $stable(nib_q));

endmodule

// File: rtl/e3_payload_ingress.sv
module e3_payload_ingress
  import e3pi_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 1536,
  parameter int unsigned OH_BITS    = 12,
  parameter int unsigned NIBBLE_W   = 4
) (
  input  logic                clk,
  input  logic                srst,
  input  logic                cfg_nibble,
  input  logic                cfg_local,
  input  logic                cfg_master,
  input  logic                rx_line_en,
  input  logic                tx_local_en,
  input  logic                frame_start_i,
  input  logic                ser_data_i,
  input  logic [NIBBLE_W-1:0] nib_data_i,
  output logic                term_req_o,
  output logic                tx_vld_o,
  output logic                tx_bit_o,
  output logic                tx_oh_o,
  output logic                tx_eof_o
);

  localparam int unsigned CW = $clog2(FRAME_BITS);
  localparam int unsigned LW = $clog2(NIBBLE_W);
  localparam logic [CW-1:0] LAST_POS = CW'(FRAME_BITS - 1);

  e3pi_mode_t    mode_q;
  logic          bit_en;
  logic [CW-1:0] pos;
  logic [LW-1:0] lane;
  logic          pos_oh;
  logic          strobe;
  logic          nib_bit;
  logic          data_bit;

  // R1, R9: mode is captured only while reset is held
  always_ff @(posedge clk) begin
    if (srst) begin
      mode_q.nibble  <= cfg_nibble;
      mode_q.local_t <= cfg_local;
      mode_q.master  <= cfg_master;
    end
  end

  e3pi_bit_timer #(.FRAME_BITS(FRAME_BITS)) timer_i (
    .clk           (clk),
    .srst          (srst),
    .mode          (mode_q),
    .rx_line_en    (rx_line_en),
    .tx_local_en   (tx_local_en),
    .frame_start_i (frame_start_i),
    .bit_en_o      (bit_en),
    .pos_o         (pos)
  );

  assign lane   = LW'(lane_of(32'(pos), NIBBLE_W));
  assign pos_oh = pos_is_oh(32'(pos), OH_BITS);
  assign strobe = mode_q.nibble ? (lane == '0) : 1'b1;

  e3pi_nibble_unpack #(.NW(NIBBLE_W)) unpack_i (
    .clk    (clk),
    .srst   (srst),
    .load   (bit_en & mode_q.nibble & (lane == '0)),
    .lane   (lane),
    .nib_in (nib_data_i),
    .bit_o  (nib_bit)
  );

  assign data_bit   = mode_q.nibble ? nib_bit : ser_data_i;
  assign term_req_o = bit_en & ~pos_oh & strobe;

  always_ff @(posedge clk) begin
    if (srst) begin
      tx_vld_o <= 1'b0;
      tx_bit_o <= 1'b0;
      tx_oh_o  <= 1'b0;
      tx_eof_o <= 1'b0;
    end else begin
      tx_vld_o <= bit_en;
      tx_bit_o <= bit_en & ~pos_oh & data_bit;
      tx_oh_o  <= bit_en & pos_oh;
      tx_eof_o <= bit_en & (pos == LAST_POS);
    end
  end

  // R5: end of frame lasts one output cycle
  p_eof_single_r5: assert property (@(posedge clk) disable iff (srst)
    tx_eof_o |=> !tx_eof_o);

  // R6: the last position of a frame is never overhead
  p_eof_not_oh_r6: assert property (@(posedge clk) disable iff (srst)
    tx_eof_o |-> !tx_oh_o);

  // R10: each bit period is followed by a valid output
  p_vld_follows_r10: assert property (@(posedge clk) disable iff (srst)
    bit_en |=> tx_vld_o);

  // R4: nibble requests are never adjacent
  p_nib_spacing_r4: assert property (@(posedge clk) disable iff (srst)
    (mode_q.nibble && term_req_o) |=> !term_req_o);

  // R9: the captured mode holds outside reset
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (srst)
    1'b1 |=> $stable(mode_q));

endmodule

// File: tb/e3_payload_ingress_tb.sv
`timescale 1ns/1ps
module e3_payload_ingress_tb_top;

  localparam int FRAME = 1536;
  localparam int OH    = 12;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic cfg_nibble = 1'b0, cfg_local = 1'b0, cfg_master = 1'b0;
  logic rx_line_en = 1'b0, tx_local_en = 1'b0, frame_start_i = 1'b0, ser_data_i = 1'b0;
  logic [3:0] nib_data_i = 4'h0;
  logic term_req_o, tx_vld_o, tx_bit_o, tx_oh_o, tx_eof_o;

  int checks = 0;
  int fails  = 0;

  // bench frame model
  bit m_nib, m_local, m_master, m_pend;
  int m_pos;
  bit [3:0] m_hold;

  always #2.5 clk = ~clk;

  e3_payload_ingress dut_i (
    .clk(clk), .srst(srst), .cfg_nibble(cfg_nibble), .cfg_local(cfg_local),
    .cfg_master(cfg_master), .rx_line_en(rx_line_en), .tx_local_en(tx_local_en),
    .frame_start_i(frame_start_i), .ser_data_i(ser_data_i), .nib_data_i(nib_data_i),
    .term_req_o(term_req_o), .tx_vld_o(tx_vld_o), .tx_bit_o(tx_bit_o),
    .tx_oh_o(tx_oh_o), .tx_eof_o(tx_eof_o)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // R9: reset with new configuration; the model restarts
  task automatic do_reset(input bit nib, input bit loc, input bit mst);
    @(negedge clk);
    srst = 1'b1; cfg_nibble = nib; cfg_local = loc; cfg_master = mst;
    rx_line_en = 1'b1; tx_local_en = 1'b1; frame_start_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(term_req_o == 1'b0, "R9", "req in reset", term_req_o, 0);
    chk({tx_vld_o, tx_bit_o, tx_oh_o, tx_eof_o} == 4'b0, "R9", "outputs in reset",
        {tx_vld_o, tx_bit_o, tx_oh_o, tx_eof_o}, 0);
    srst = 1'b0; rx_line_en = 1'b0; tx_local_en = 1'b0; frame_start_i = 1'b0;
    m_nib = nib; m_local = loc; m_master = mst; m_pend = 1'b0; m_pos = 0; m_hold = 4'h0;
  endtask

  // One cycle: drive at the falling edge, check the request, then the registered outputs.
  task automatic step(input bit rxe, input bit txe, input bit fs, input bit sd, input bit [3:0] nd);
    bit en, slave, take, oh, req, eb;
    int p, lane;
    @(negedge clk);
    rx_line_en = rxe; tx_local_en = txe; frame_start_i = fs; ser_data_i = sd; nib_data_i = nd;
    en    = m_local ? txe : rxe;                    // R2
    slave = m_local && !m_master;
    take  = slave && (m_pend || fs);                // R8
    p     = take ? 0 : m_pos;
    oh    = p < OH;                                 // R6
    lane  = p % 4;
    req   = en && !oh && (!m_nib || lane == 0);
    #1;
    chk(term_req_o == req, m_nib ? "R4" : "R3", "term_req_o", term_req_o, req);
    if (m_nib) eb = (lane == 0) ? nd[3] : m_hold[3 - lane];
    else eb = sd;
    if (en) begin
      if (m_nib && lane == 0) m_hold = nd;
      m_pos = (p == FRAME - 1) ? 0 : p + 1;         // R5
      m_pend = 1'b0;
    end else if (slave && fs) begin
      m_pend = 1'b1;
    end
    @(posedge clk); #1;
    chk(tx_vld_o == en, "R10", "tx_vld_o", tx_vld_o, en);
    chk(tx_oh_o == (en && oh), "R6", "tx_oh_o", tx_oh_o, en && oh);
    chk(tx_eof_o == (en && p == FRAME - 1), "R5", "tx_eof_o", tx_eof_o, en && p == FRAME - 1);
    chk(tx_bit_o == (en && !oh && eb), m_nib ? "R4" : "R3", "tx_bit_o", tx_bit_o, en && !oh && eb);
  endtask

  // rate: 0 = every cycle, n = enable with probability 1/n; the other enable toggles freely
  task automatic run(input int cycles, input int rate, input bit fs_noise);
    for (int i = 0; i < cycles; i++) begin
      bit e, o, f;
      e = (rate == 0) ? 1'b1 : ($urandom % rate == 0);
      o = $urandom % 2;
      f = fs_noise ? ($urandom % 97 == 0) : 1'b0;
      if (m_local) step(o, e, f, $urandom % 2, 4'($urandom));
      else         step(e, o, f, $urandom % 2, 4'($urandom));
    end
  endtask

  // R1, R2, R3, R5: serial loop-timed at full rate, local enable toggling
  task automatic t_serial_loop();
    do_reset(1'b0, 1'b0, 1'b0);
    run(3200, 0, 1'b1);   // strobes ignored (R7)
  endtask

  // R2, R7: serial local-timed master, receive enable and strobes ignored
  task automatic t_serial_master();
    do_reset(1'b0, 1'b1, 1'b1);
    run(4000, 2, 1'b1);
  endtask

  // R8: serial slave, strobe outside a bit period and inside one
  task automatic t_serial_slave();
    do_reset(1'b0, 1'b1, 1'b0);
    run(700, 2, 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'h0);    // pending strobe
    step(1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
    step(1'b0, 1'b1, 1'b0, 1'b1, 4'h0);    // this period is position 0
    chk(tx_oh_o == 1'b1, "R8", "resync to overhead", tx_oh_o, 1);
    run(400, 1, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b1, 4'h0);    // strobe in a bit period
    chk(tx_oh_o == 1'b1, "R8", "in-period strobe", tx_oh_o, 1);
    run(1700, 0, 1'b0);
  endtask

  // R4, R2: nibble loop-timed
  task automatic t_nibble_loop();
    do_reset(1'b1, 1'b0, 1'b0);
    run(4000, 2, 1'b1);
  endtask

  // R4, R7: nibble local master at full rate
  task automatic t_nibble_master();
    do_reset(1'b1, 1'b1, 1'b1);
    run(3200, 0, 1'b1);
  endtask

  // R4, R8: nibble slave with random mid-frame strobes
  task automatic t_nibble_slave();
    do_reset(1'b1, 1'b1, 1'b0);
    run(3000, 2, 1'b1);
    run(2000, 0, 1'b0);
  endtask

  // R9: configuration pins change without reset, then with reset
  task automatic t_mode_change();
    do_reset(1'b0, 1'b0, 1'b0);
    run(300, 0, 1'b0);
    @(negedge clk);
    cfg_nibble = 1'b1; cfg_local = 1'b1; cfg_master = 1'b0;
    run(600, 0, 1'b1);    // model keeps serial loop-timed
    do_reset(1'b1, 1'b1, 1'b0);
    run(600, 0, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_serial_loop();
    t_serial_master();
    t_serial_slave();
    t_nibble_loop();
    t_nibble_master();
    t_nibble_slave();
    t_mode_change();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule